// File: doc/BRIEF.md
# Programmable Serial Transmitter with Synchronous Clock Output

This block turns 8-bit or 9-bit words into asynchronous serial frames on a single line. A frame has a start bit, the data bits sent least significant first, and one, one and a half or two stop bits. Parity is optional. When it is on, the top bit of the word slot carries the computed parity instead of data. A one-word holding register sits in front of the shifter, so software can queue the next word while the current one is still going out. Frames then follow each other with no idle gap.

Timing comes from an external `halfTick` strobe that pulses once per half bit time. Each bit lasts two half ticks. This half-bit timebase gives the 1.5-stop-bit length and places the mid-bit edges of the optional synchronous clock. The clock runs only during the data bits of ordinary data frames. Its idle level, its phase and the pulse on the final data bit are all programmable. Two further frame kinds exist. A break request sends a frame of zeros. Toggling the enable low and then high while a frame is running queues one all-ones idle frame. Parity and word-length settings are sampled when a frame starts, so a change only affects the next frame.

Top module: `uartSyncTx`

## Requirements
- R1: Out of reset, `txLine` is 1, `sclkOut` equals `clkPol`, and `dataEmpty` is 1. `txDone` is 1 and `breakBusy` is 0.
- R2: Every line change happens on the clock edge that samples `halfTick` high. A data frame is one bit of 0, then N data bits sent least significant bit first, then the stop bits at 1. N is 9 when `longWord` is 1 and 8 otherwise. Each bit lasts two half ticks.
- R3: With `parityEn` at 1, the last data bit slot (bit 8 for N=9, bit 7 for N=8) carries the parity of the N-1 lower bits. It is even parity when `parityOdd` is 0 and odd parity when it is 1.
- R4: `parityEn`, `parityOdd` and `longWord` are sampled when a frame starts. Changing them during a frame leaves that frame unchanged.
- R5: `stopSel` selects the stop length: code 00 gives 1 bit (2 half ticks), code 10 gives 2 bits (4), code 11 gives 1.5 bits (3), and the spare code 01 gives 1 bit.
- R6: A `wrStrobe` loads the holding register and drops `dataEmpty` on the next cycle. `dataEmpty` rises when the word moves to the shifter at a frame start. A word queued during a frame starts right at the end of that frame's stop bits.
- R7: `txDone` falls when a frame starts. It rises when the stop bits end and no word, break or idle frame is pending. While `txDone` is 1, `txLine` is 1.
- R8: A `breakSet` pulse raises `breakBusy` on the next cycle. A break frame then sends 1+N bits of 0, followed by one stop bit at 1, with no serial clock pulses. `breakBusy` falls when that stop bit begins.
- R9: With `txEn` at 0, no frame starts. After the edge that samples `txEn` rising, the first two half ticks pass with the line idle, and a frame may begin on the third.
- R10: If `txEn` rises again while a frame is in progress, N+2 bit times of 1 are sent after that frame, before any pending word.
- R11: `sclkOut` equals `clkPol` whenever `clkEn` is 0, and outside the data bits of data frames.
- R12: When `clkEn` is 1, `sclkOut` takes the active level (the inverse of `clkPol`) during one half of each data bit. With `clkPha` at 0 this is the second half, so the first edge falls at mid-bit. With `clkPha` at 1 it is the first half.
- R13: When `lastPulse` is 0, the final data bit of a frame gets no clock pulse. When it is 1, the final bit gets one like every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| halfTick | input | 1 | One-cycle strobe, twice per bit time |
| txEn | input | 1 | Transmitter enable |
| wrData | input | 9 | Word to send |
| wrStrobe | input | 1 | Loads `wrData` into the holding register |
| longWord | input | 1 | 1: 9 data bits, 0: 8 data bits |
| parityEn | input | 1 | Parity insertion on |
| parityOdd | input | 1 | 0: even parity, 1: odd parity |
| stopSel | input | 2 | Stop length code |
| breakSet | input | 1 | Requests one break frame |
| clkEn | input | 1 | Enables the synchronous clock |
| clkPol | input | 1 | Idle level of the synchronous clock |
| clkPha | input | 1 | Active half of each data bit |
| lastPulse | input | 1 | Pulse on the final data bit |
| txLine | output | 1 | Serial output |
| sclkOut | output | 1 | Synchronous clock output |
| dataEmpty | output | 1 | Holding register is free |
| txDone | output | 1 | Transmission complete |
| breakBusy | output | 1 | Break request still pending |

## Verification
The bench measures the distance between consecutive start bits of back-to-back frames. A design that counts stop halves wrong, or that treats the spare code as something other than one stop bit, shifts the second start by a half or whole bit. It changes the parity settings in the middle of a frame: a design that reads them live corrupts the frame already on the line. It checks the exact half tick where the first frame starts after enable: a design without the delay starts one bit early. It checks that toggling the enable mid-frame adds exactly N+2 idle bits before the next word. It checks the half-by-half clock pattern for both phases with the last-bit pulse suppressed, where an off-by-one in the last-bit index would clip the wrong pulse. It also checks that a break holds the line low for the full frame and releases its request as the stop bit begins.

// File: rtl/uartSyncTxPkg.sv
package uartSyncTxPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } txStateT;

  typedef enum logic [1:0] {
    FR_DATA,
    FR_BREAK,
    FR_IDLE
  } frameKindT;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadData;
    logic loadBreak;
    logic loadIdle;
    logic shiftBit;
    logic clkActive;
  } txStrobeT;

endpackage

// File: rtl/uartSyncTxCtrl.sv
module uartSyncTxCtrl
  import uartSyncTxPkg::*;
#(
  parameter int DATA_W          = 9,
  parameter int EN_DELAY_HALVES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     halfTick,
  input  logic     txEn,
  input  logic     longWord,
  input  logic [1:0] stopSel,
  input  logic     breakSet,
  input  logic     clkEn,
  input  logic     clkPha,
  input  logic     lastPulse,
  input  logic     dataEmpty,
  output txStrobeT strobe,
  output logic     breakBusy,
  output logic     txDone
);

  localparam int IDX_W  = $clog2(DATA_W);
  localparam int STOP_W = 3;
  localparam int DLY_W  = $clog2(EN_DELAY_HALVES + 1);
  localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(DATA_W - 2);

  txStateT              state;
  frameKindT            kind;
  frameKindT            nextKind;
  logic                 halfPh;
  logic [IDX_W-1:0]     bitIdx;
  logic [IDX_W-1:0]     lastIdx;
  logic [STOP_W-1:0]    stopLeft;
  logic [STOP_W-1:0]    frameStop;
  logic                 frameLong;
  logic                 breakPend;
  logic                 preamblePend;
  logic                 txEnPrev;
  logic [DLY_W-1:0]     enDelay;
  logic                 enRise;
  logic                 canStart;
  logic                 startNow;
  logic                 stopEnd;
  logic                 dataEnd;
  logic                 nothingPending;

  // stop length in half ticks, minus one
  function automatic logic [STOP_W-1:0] stopLastHalf(input logic [1:0] sel);
    case (sel)
      2'b10:   return STOP_W'(3);
      2'b11:   return STOP_W'(2);
      default: return STOP_W'(1);
    endcase
  endfunction

  always_comb begin
    enRise         = txEn & ~txEnPrev;
    nothingPending = dataEmpty & ~breakPend & ~preamblePend;
    canStart       = txEn & txEnPrev & (enDelay == '0) & ~nothingPending;
    nextKind       = preamblePend ? FR_IDLE : (breakPend ? FR_BREAK : FR_DATA);
    lastIdx        = frameLong ? LAST_LONG : LAST_SHORT;
    stopEnd        = halfTick & (state == ST_STOP) & (stopLeft == '0);
    startNow       = halfTick & canStart & ((state == ST_IDLE) | stopEnd);
    dataEnd        = halfTick & (state == ST_DATA) & halfPh & (bitIdx == lastIdx);

    strobe.loadData  = startNow & (nextKind == FR_DATA);
    strobe.loadBreak = startNow & (nextKind == FR_BREAK);
    strobe.loadIdle  = startNow & (nextKind == FR_IDLE);
    strobe.shiftBit  = halfTick & halfPh & ((state == ST_START) | (state == ST_DATA));
    strobe.clkActive = (state == ST_DATA) & (kind == FR_DATA) & clkEn
                     & (halfPh ^ clkPha) & ((bitIdx != lastIdx) | lastPulse);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      kind         <= FR_DATA;
      halfPh       <= 1'b0;
      bitIdx       <= '0;
      stopLeft     <= '0;
      frameStop    <= '0;
      frameLong    <= 1'b0;
      breakPend    <= 1'b0;
      preamblePend <= 1'b0;
      txEnPrev     <= 1'b0;
      enDelay      <= '0;
      txDone       <= 1'b1;
    end else begin
      txEnPrev <= txEn;

      if (enRise)
        enDelay <= DLY_W'(EN_DELAY_HALVES);
      else if (halfTick && enDelay != '0)
        enDelay <= enDelay - DLY_W'(1);

      if (enRise && state != ST_IDLE)
        preamblePend <= 1'b1;
      else if (strobe.loadIdle)
        preamblePend <= 1'b0;

      if (breakSet)
        breakPend <= 1'b1;
      else if (dataEnd && kind == FR_BREAK)
        breakPend <= 1'b0;

      if (startNow)
        txDone <= 1'b0;
      else if (stopEnd && nothingPending)
        txDone <= 1'b1;

      if (startNow) begin
        state     <= ST_START;
        halfPh    <= 1'b0;
        kind      <= nextKind;
        frameLong <= longWord;
        frameStop <= (nextKind == FR_DATA) ? stopLastHalf(stopSel) : STOP_W'(1);
      end else if (halfTick) begin
        case (state)
          ST_START: begin
            if (!halfPh) begin
              halfPh <= 1'b1;
            end else begin
              state  <= ST_DATA;
              halfPh <= 1'b0;
              bitIdx <= '0;
            end
          end
          ST_DATA: begin
            if (!halfPh) begin
              halfPh <= 1'b1;
            end else if (bitIdx == lastIdx) begin
              state    <= ST_STOP;
              halfPh   <= 1'b0;
              stopLeft <= frameStop;
            end else begin
              bitIdx <= bitIdx + IDX_W'(1);
              halfPh <= 1'b0;
            end
          end
          ST_STOP: begin
            if (stopLeft != '0)
              stopLeft <= stopLeft - STOP_W'(1);
            else
              state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign breakBusy = breakPend;

endmodule

// File: rtl/uartSyncTxDatapath.sv
module uartSyncTxDatapath
  import uartSyncTxPkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobeT          strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrStrobe,
  input  logic              longWord,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              clkPol,
  output logic              txLine,
  output logic              sclkOut,
  output logic              dataEmpty
);

  localparam int MSB_LONG  = DATA_W - 1;
  localparam int MSB_SHORT = DATA_W - 2;
  localparam logic [DATA_W-1:0] LONG_MASK  = {1'b0, {(DATA_W - 1){1'b1}}};
  localparam logic [DATA_W-1:0] SHORT_MASK = {2'b00, {(DATA_W - 2){1'b1}}};
  localparam logic [DATA_W-1:0] SHORT_BREAK = {1'b1, {(DATA_W - 1){1'b0}}};

  logic [DATA_W-1:0] holding;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] framed;
  logic [DATA_W-1:0] breakVec;
  logic              parityBit;

  always_comb begin
    framed    = holding;
    parityBit = (^(holding & (longWord ? LONG_MASK : SHORT_MASK))) ^ parityOdd;
    // unused top slot in short mode is shifted out as the first stop half
    if (!longWord) framed[MSB_LONG] = 1'b1;
    if (parityEn) begin
      if (longWord) framed[MSB_LONG]  = parityBit;
      else          framed[MSB_SHORT] = parityBit;
    end
    breakVec = longWord ? '0 : SHORT_BREAK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holding   <= '0;
      dataEmpty <= 1'b1;
      shiftReg  <= '1;
      txLine    <= 1'b1;
    end else begin
      if (wrStrobe) begin
        holding   <= wrData;
        dataEmpty <= 1'b0;
      end else if (strobe.loadData) begin
        dataEmpty <= 1'b1;
      end

      if (strobe.loadData) begin
        shiftReg <= framed;
        txLine   <= 1'b0;
      end else if (strobe.loadBreak) begin
        shiftReg <= breakVec;
        txLine   <= 1'b0;
      end else if (strobe.loadIdle) begin
        shiftReg <= '1;
        txLine   <= 1'b1;
      end else if (strobe.shiftBit) begin
        shiftReg <= {1'b1, shiftReg[DATA_W-1:1]};
        txLine   <= shiftReg[0];
      end
    end
  end

  assign sclkOut = clkPol ^ strobe.clkActive;

endmodule

// File: rtl/uartSyncTx.sv
module uartSyncTx
  import uartSyncTxPkg::*;
#(
  parameter int DATA_W          = 9,
  parameter int EN_DELAY_HALVES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              halfTick,
  input  logic              txEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrStrobe,
  input  logic              longWord,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic [1:0]        stopSel,
  input  logic              breakSet,
  input  logic              clkEn,
  input  logic              clkPol,
  input  logic              clkPha,
  input  logic              lastPulse,
  output logic              txLine,
  output logic              sclkOut,
  output logic              dataEmpty,
  output logic              txDone,
  output logic              breakBusy
);

  txStrobeT strobe;

  uartSyncTxCtrl #(
    .DATA_W          (DATA_W),
    .EN_DELAY_HALVES (EN_DELAY_HALVES)
  ) ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .halfTick  (halfTick),
    .txEn      (txEn),
    .longWord  (longWord),
    .stopSel   (stopSel),
    .breakSet  (breakSet),
    .clkEn     (clkEn),
    .clkPha    (clkPha),
    .lastPulse (lastPulse),
    .dataEmpty (dataEmpty),
    .strobe    (strobe),
    .breakBusy (breakBusy),
    .txDone    (txDone)
  );

  uartSyncTxDatapath #(
    .DATA_W (DATA_W)
  ) dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .wrStrobe  (wrStrobe),
    .longWord  (longWord),
    .parityEn  (parityEn),
    .parityOdd (parityOdd),
    .clkPol    (clkPol),
    .txLine    (txLine),
    .sclkOut   (sclkOut),
    .dataEmpty (dataEmpty)
  );

endmodule

// File: rtl/uartSyncTxChk.sv
module uartSyncTxChk (
  input logic clk,
  input logic rstN,
  input logic halfTick,
  input logic wrStrobe,
  input logic breakSet,
  input logic clkEn,
  input logic clkPol,
  input logic txLine,
  input logic sclkOut,
  input logic dataEmpty,
  input logic txDone,
  input logic breakBusy
);

  // R2
  line_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !halfTick |=> $stable(txLine));

  // R6
  write_fills_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !dataEmpty);

  // R6
  empty_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataEmpty) |-> $past(halfTick));

  // R7
  done_line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> txLine);

  // R7
  done_falls_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txDone) |-> $past(halfTick));

  // R8
  break_latched_chk: assert property (@(posedge clk) disable iff (!rstN)
    breakSet |=> breakBusy);

  // R8
  break_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (breakBusy && !halfTick) |=> breakBusy);

  // R11
  sclk_off_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |-> (sclkOut == clkPol));

endmodule

bind uartSyncTx uartSyncTxChk chk (
  .clk       (clk),
  .rstN      (rstN),
  .halfTick  (halfTick),
  .wrStrobe  (wrStrobe),
  .breakSet  (breakSet),
  .clkEn     (clkEn),
  .clkPol    (clkPol),
  .txLine    (txLine),
  .sclkOut   (sclkOut),
  .dataEmpty (dataEmpty),
  .txDone    (txDone),
  .breakBusy (breakBusy)
);

// File: tb/uartSyncTx_test.sv
`timescale 1ns/1ps
module uartSyncTx_test;

  localparam int REC_MAX  = 128;
  localparam int WATCHDOG = 100000;

  logic       clk = 1'b0;
  logic       rstN;
  logic       halfTick;
  logic       txEn;
  logic [8:0] wrData;
  logic       wrStrobe;
  logic       longWord;
  logic       parityEn;
  logic       parityOdd;
  logic [1:0] stopSel;
  logic       breakSet;
  logic       clkEn;
  logic       clkPol;
  logic       clkPha;
  logic       lastPulse;
  logic       txLine;
  logic       sclkOut;
  logic       dataEmpty;
  logic       txDone;
  logic       breakBusy;

  int checks   = 0;
  int failures = 0;

  logic recLine [0:REC_MAX-1];
  logic recSclk [0:REC_MAX-1];
  logic recDone [0:REC_MAX-1];
  logic recBusy [0:REC_MAX-1];

  always #5 clk = ~clk;

  uartSyncTx uut (
    .clk       (clk),
    .rstN      (rstN),
    .halfTick  (halfTick),
    .txEn      (txEn),
    .wrData    (wrData),
    .wrStrobe  (wrStrobe),
    .longWord  (longWord),
    .parityEn  (parityEn),
    .parityOdd (parityOdd),
    .stopSel   (stopSel),
    .breakSet  (breakSet),
    .clkEn     (clkEn),
    .clkPol    (clkPol),
    .clkPha    (clkPha),
    .lastPulse (lastPulse),
    .txLine    (txLine),
    .sclkOut   (sclkOut),
    .dataEmpty (dataEmpty),
    .txDone    (txDone),
    .breakBusy (breakBusy)
  );

  // half-bit strobe: one cycle in four
  initial begin
    halfTick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      halfTick = 1'b1;
      @(negedge clk);
      halfTick = 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitHalves(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!halfTick);
    end
    @(negedge clk);
  endtask

  task automatic recordHalves(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!halfTick);
      @(negedge clk);
      recLine[i] = txLine;
      recSclk[i] = sclkOut;
      recDone[i] = txDone;
      recBusy[i] = breakBusy;
    end
  endtask

  task automatic writeWord(input logic [8:0] w);
    wrData   = w;
    wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic waitIdle();
    while (!(txDone && dataEmpty && !breakBusy)) @(negedge clk);
    waitHalves(2);
  endtask

  function automatic int findStart(input int from);
    for (int i = from; i < REC_MAX; i++) begin
      if (i == 0) begin
        if (recLine[0] === 1'b0) return 0;
      end else if (recLine[i] === 1'b0 && recLine[i-1] === 1'b1) begin
        return i;
      end
    end
    return -1;
  endfunction

  function automatic logic [8:0] expBits(input logic [8:0] w, input logic lng,
                                         input logic pen, input logic odd);
    logic [8:0] b;
    logic       p;
    b = w;
    p = lng ? (^w[7:0]) ^ odd : (^w[6:0]) ^ odd;
    if (pen) begin
      if (lng) b[8] = p;
      else     b[7] = p;
    end
    return b;
  endfunction

  // R1
  task automatic testReset();
    check("R1", {31'd0, txLine},    32'd1, "line idle after reset");
    check("R1", {31'd0, sclkOut},   {31'd0, clkPol}, "sclk idle after reset");
    check("R1", {31'd0, dataEmpty}, 32'd1, "empty after reset");
    check("R1", {31'd0, txDone},    32'd1, "done after reset");
    check("R1", {31'd0, breakBusy}, 32'd0, "no break after reset");
  endtask

  // two back-to-back frames: format, parity, stop length, holding register, done
  task automatic testFrame(input logic [8:0] a, input logic [8:0] b,
                           input logic lng, input logic pen, input logic odd,
                           input logic [1:0] sel, input int stopHalves,
                           input string tag);
    int s;
    int s2;
    int n;
    int zeros;
    logic [8:0] ea;
    logic [8:0] eb;
    waitIdle();
    longWord  = lng;
    parityEn  = pen;
    parityOdd = odd;
    stopSel   = sel;
    n  = lng ? 9 : 8;
    ea = expBits(a, lng, pen, odd);
    eb = expBits(b, lng, pen, odd);
    fork
      recordHalves(56);
      begin
        writeWord(a);
        while (!dataEmpty) @(negedge clk);
        writeWord(b);
        check("R6", {31'd0, dataEmpty}, 32'd0, {tag, " second word held"});
      end
    join
    s = findStart(0);
    check("R2", (s >= 0) ? 32'd1 : 32'd0, 32'd1, {tag, " start bit seen"});
    if (s < 0) return;
    check("R2", {30'd0, recLine[s], recLine[s+1]}, 32'd0, {tag, " start bit"});
    check("R7", {31'd0, recDone[s]}, 32'd0, {tag, " done low in frame"});
    for (int k = 0; k < n; k++) begin
      check((pen && k == n - 1) ? "R3" : "R2",
            {30'd0, recLine[s+2+2*k], recLine[s+3+2*k]}, {30'd0, ea[k], ea[k]},
            $sformatf("%s word A bit %0d", tag, k));
    end
    check("R2", {31'd0, recLine[s+2+2*n]}, 32'd1, {tag, " stop level"});
    s2 = findStart(s + 2 + 2 * n);
    check("R5", s2 - s, 2 + 2 * n + stopHalves, {tag, " start spacing"});
    if (s2 >= 0) begin
      for (int k = 0; k < n; k++) begin
        check((pen && k == n - 1) ? "R3" : "R6",
              {31'd0, recLine[s2+2+2*k]}, {31'd0, eb[k]},
              $sformatf("%s word B bit %0d", tag, k));
      end
    end
    zeros = 0;
    for (int i = 0; i < 56; i++) if (recSclk[i] !== clkPol) zeros++;
    check("R11", zeros, 32'd0, {tag, " sclk idle with clock off"});
    waitIdle();
    check("R7", {31'd0, txDone}, 32'd1, {tag, " done after frames"});
    check("R6", {31'd0, dataEmpty}, 32'd1, {tag, " empty after frames"});
  endtask

  // R4: parity setting changed while a frame is on the line
  task automatic testDeferred();
    int s;
    int s2;
    waitIdle();
    longWord = 1'b0; parityEn = 1'b0; parityOdd = 1'b0; stopSel = 2'b00;
    fork
      recordHalves(48);
      begin
        writeWord(9'h083);
        while (!dataEmpty) @(negedge clk);
        parityEn = 1'b1;
        writeWord(9'h083);
      end
    join
    s = findStart(0);
    s2 = (s >= 0) ? findStart(s + 18) : -1;
    check("R4", (s >= 0 && s2 >= 0) ? 32'd1 : 32'd0, 32'd1, "both frames seen");
    if (s < 0 || s2 < 0) return;
    check("R4", {31'd0, recLine[s+2+14]},  32'd1, "frame A keeps data bit 7");
    check("R4", {31'd0, recLine[s2+2+14]}, 32'd0, "frame B carries even parity");
    parityEn = 1'b0;
    waitIdle();
  endtask

  // R8
  task automatic testBreak();
    int s;
    int ones;
    int clks;
    waitIdle();
    longWord = 1'b0; clkEn = 1'b1; clkPol = 1'b0; clkPha = 1'b0; lastPulse = 1'b1;
    breakSet = 1'b1;
    @(negedge clk);
    breakSet = 1'b0;
    check("R8", {31'd0, breakBusy}, 32'd1, "request latched");
    recordHalves(30);
    s = findStart(0);
    check("R8", (s >= 0) ? 32'd1 : 32'd0, 32'd1, "break frame seen");
    if (s < 0) return;
    ones = 0;
    for (int i = 0; i < 18; i++) if (recLine[s+i] !== 1'b0) ones++;
    check("R8", ones, 32'd0, "line low for start and data slots");
    check("R8", {31'd0, recLine[s+18]}, 32'd1, "stop bit high");
    check("R8", {31'd0, recBusy[s+17]}, 32'd1, "busy held through data");
    check("R8", {31'd0, recBusy[s+18]}, 32'd0, "busy released at stop");
    clks = 0;
    for (int i = 0; i < 30; i++) if (recSclk[i] !== clkPol) clks++;
    check("R8", clks, 32'd0, "no clock pulses in break");
    clkEn = 1'b0;
    waitIdle();
  endtask

  // R11, R12, R13
  task automatic testSclk(input logic pol, input logic pha, input logic last);
    int s;
    logic act;
    logic e0;
    logic e1;
    waitIdle();
    longWord = 1'b0; clkEn = 1'b1; clkPol = pol; clkPha = pha; lastPulse = last;
    @(negedge clk);
    check("R11", {31'd0, sclkOut}, {31'd0, pol}, "sclk idle level");
    fork
      recordHalves(30);
      writeWord(9'h05A);
    join
    s = findStart(0);
    check("R12", (s >= 0) ? 32'd1 : 32'd0, 32'd1, "clocked frame seen");
    if (s < 0) return;
    check("R11", {30'd0, recSclk[s], recSclk[s+1]}, {30'd0, pol, pol}, "sclk idle in start bit");
    for (int k = 0; k < 8; k++) begin
      act = (k != 7) || last;
      e0  = (pha && act) ? ~pol : pol;
      e1  = (!pha && act) ? ~pol : pol;
      check((k == 7) ? "R13" : "R12",
            {30'd0, recSclk[s+2+2*k], recSclk[s+3+2*k]}, {30'd0, e0, e1},
            $sformatf("sclk pol=%0d pha=%0d last=%0d bit %0d", pol, pha, last, k));
    end
    check("R11", {31'd0, recSclk[s+18]}, {31'd0, pol}, "sclk idle in stop bit");
    clkEn = 1'b0; clkPol = 1'b0;
    waitIdle();
  endtask

  // R10
  task automatic testPreamble();
    int s;
    int s2;
    int zeros;
    waitIdle();
    longWord = 1'b0; parityEn = 1'b0; stopSel = 2'b00;
    fork
      recordHalves(64);
      begin
        writeWord(9'h0F0);
        while (!dataEmpty) @(negedge clk);
        txEn = 1'b0;
        @(negedge clk);
        txEn = 1'b1;
        writeWord(9'h055);
      end
    join
    s = findStart(0);
    s2 = (s >= 0) ? findStart(s + 18) : -1;
    check("R10", s2 - s, 32'd40, "idle frame inserted between words");
    if (s < 0 || s2 < 0) return;
    zeros = 0;
    for (int i = 20; i < 40; i++) if (recLine[s+i] !== 1'b1) zeros++;
    check("R10", zeros, 32'd0, "line high during idle frame");
    check("R10", {31'd0, recLine[s2+2]}, 32'd1, "pending word follows");
    waitIdle();
  endtask

  // R9
  task automatic testEnableDelay();
    int zeros;
    waitIdle();
    txEn = 1'b0;
    @(negedge clk);
    writeWord(9'h000);
    recordHalves(6);
    zeros = 0;
    for (int i = 0; i < 6; i++) if (recLine[i] !== 1'b1) zeros++;
    check("R9", zeros, 32'd0, "no frame while disabled");
    check("R9", {31'd0, dataEmpty}, 32'd0, "word still held while disabled");
    do @(posedge clk); while (!halfTick);
    @(negedge clk);
    txEn = 1'b1;
    recordHalves(4);
    check("R9", {30'd0, recLine[0], recLine[1]}, 32'd3, "idle for one bit after enable");
    check("R9", {31'd0, recLine[2]}, 32'd0, "start on third half tick");
    waitIdle();
  endtask

  initial begin
    rstN = 1'b0; txEn = 1'b0; wrData = '0; wrStrobe = 1'b0;
    longWord = 1'b0; parityEn = 1'b0; parityOdd = 1'b0; stopSel = 2'b00;
    breakSet = 1'b0; clkEn = 1'b0; clkPol = 1'b0; clkPha = 1'b0; lastPulse = 1'b1;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    txEn = 1'b1;
    waitHalves(4);
    testFrame(9'h0A5, 9'h03C, 1'b0, 1'b0, 1'b0, 2'b00, 2, "F8 1stop");
    testFrame(9'h1C3, 9'h12E, 1'b1, 1'b0, 1'b0, 2'b10, 4, "F9 2stop");
    testFrame(9'h015, 9'h06A, 1'b0, 1'b1, 1'b0, 2'b11, 3, "F8 even 1.5stop");
    testFrame(9'h0F0, 9'h101, 1'b1, 1'b1, 1'b1, 2'b01, 2, "F9 odd spare");
    testDeferred();
    testBreak();
    testSclk(1'b0, 1'b0, 1'b1);
    testSclk(1'b1, 1'b1, 1'b0);
    testPreamble();
    testEnableDelay();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog run stalled actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule